// File: doc/BRIEF.md
# Two-Phase Alternating Energy Pulse Generator

The block converts a stream of signed total-power samples into slow energy pulses on two outputs. Each valid sample is added to an accumulator. Whenever the sum reaches the threshold chosen by the rate select, the threshold is subtracted and one pulse is scheduled. Successive pulses go to the two outputs in turn, which suits a two-coil stepper counter. The pulse rate therefore follows the average real power.

Pulses have a fixed nominal width. When crossings arrive faster than twice that width, the width becomes half of the measured crossing interval. A minimum low time separates any pulse from the next one. Crossings that arrive while a pulse or gap is in progress are queued. An optional no-load guard holds the accumulator at zero while the incoming power is below a small floor, so the meter does not creep at no load.

Top module: `dual_phase_pulser`

## Requirements
- R1: Reset is synchronous and active high. It drives both outputs low and clears the accumulator, so a full threshold of new energy is needed before the first pulse.
- R2: Only samples with `smp_vld` high are added. Each time the running sum reaches the threshold, exactly one pulse is produced and the excess above the threshold is carried forward.
- R3: The threshold is `BASE_THR >> rate_sel`. `rate_sel` = 0 is the slowest rate and 3 is the fastest.
- R4: Pulses alternate between `out_a` and `out_b`. The first pulse after reset is on `out_a`, and the two outputs are never high together.
- R5: A pulse is `WIDTH_NOM` cycles wide when no crossing has occurred since reset, or when the latest crossing interval is at least 2*`WIDTH_NOM` cycles.
- R6: When the latest crossing interval P is below 2*`WIDTH_NOM`, the width is floor(P/2) cycles, with a minimum of 1.
- R7: At least `MIN_GAP` low cycles on both outputs separate the end of one pulse from the start of the next.
- R8: Crossings that arrive while the output is busy are queued, up to 2^`PEND_W`-1 of them, and are issued later without loss.
- R9: With `nold_en` high, a valid sample below `NOLOAD_MIN` clears the accumulator to zero. With `nold_en` low, such samples accumulate normally.
- R10: Negative samples reduce the accumulator, but never below zero, and never cause a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Power sample strobe |
| smp_pwr | input | PWR_W | Signed total-power sample |
| rate_sel | input | 2 | Threshold select (0 is slowest) |
| nold_en | input | 1 | No-load guard enable |
| out_a | output | 1 | First-phase pulse output |
| out_b | output | 1 | Second-phase pulse output |

## Verification
The bench sweeps every rate select against several sample magnitudes at a fixed strobe spacing. It compares the pulse count on each output with floor(N*s/threshold), which separates threshold, carry and alternation faults. Constant streams with crossing intervals of 16, 32, 40 and 64 cycles probe the width rule on both sides of its 2*`WIDTH_NOM` boundary. A saturating burst exposes the minimum gap and the one-cycle width floor. Sequences of mixed-sign and sub-floor samples, with fixed expected sums, show whether negative power is clamped at zero and whether the no-load guard zeroes the accumulator rather than merely pausing it.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HIGH = 2'd1,
    PS_GAP  = 2'd2
  } pstate_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dpp_accum.sv
module dpp_accum #(
  parameter int PWR_W      = 16,
  parameter int ACC_W      = 32,
  parameter int BASE_THR   = 1048576,
  parameter int NOLOAD_MIN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [PWR_W-1:0] smp_pwr,
  input  logic [1:0]              rate_sel,
  input  logic                    nold_en,
  output logic                    xing
);
  localparam int SW    = ACC_W + 1;
  localparam int NRATE = 4;

  logic signed [ACC_W-1:0] acc;
  logic signed [SW-1:0]    sum;
  logic signed [SW-1:0]    thr_w;
  logic [ACC_W-1:0]        thr_tab [NRATE];
  logic                    below;

  genvar g;
  generate
    for (g = 0; g < NRATE; g++) begin : g_thr
      assign thr_tab[g] = ACC_W'(BASE_THR >> g);
    end
  endgenerate

  always_comb begin
    thr_w = $signed({1'b0, thr_tab[rate_sel]});
    sum   = $signed({acc[ACC_W-1], acc}) + $signed({{(SW-PWR_W){smp_pwr[PWR_W-1]}}, smp_pwr});
    below = nold_en && (smp_pwr < $signed(PWR_W'(NOLOAD_MIN)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      xing <= 1'b0;
    end else begin
      xing <= 1'b0;
      if (smp_vld) begin
        if (below) begin
          acc <= '0;
        end else if (sum >= thr_w) begin
          acc  <= ACC_W'(sum - thr_w);
          xing <= 1'b1;
        end else if (sum < 0) begin
          acc <= '0;
        end else begin
          acc <= ACC_W'(sum);
        end
      end
    end
  end

  AST_NOLOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && below) |=> (acc == '0)); // R9
  AST_ACC_NONNEG: assert property (@(posedge clk) disable iff (rst)
    !acc[ACC_W-1]); // R10
  AST_XING_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
    xing |-> $past(smp_vld)); // R2
endmodule

// File: rtl/dpp_period.sv
module dpp_period #(
  parameter int CAP = 40,
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xing,
  output logic [CW-1:0] per_now,
  output logic          fast
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] per_q;

  always_comb begin
    per_now = xing ? cnt : per_q;
    fast    = (per_now < CW'(CAP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CW'(CAP);
      per_q <= CW'(CAP);
    end else if (xing) begin
      cnt   <= CW'(1);
      per_q <= cnt;
    end else if (cnt < CW'(CAP)) begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CW'(CAP)) && (per_q <= CW'(CAP))); // R6
endmodule

// File: rtl/dpp_driver.sv
module dpp_driver
  import dpp_pkg::*;
#(
  parameter int WIDTH_NOM = 2750000,
  parameter int MIN_GAP   = 4,
  parameter int PEND_W    = 3,
  parameter int CAP       = 2 * WIDTH_NOM,
  localparam int CW       = $clog2(CAP + 1),
  localparam int KW       = $clog2(max2(WIDTH_NOM, MIN_GAP) + 1),
  localparam int GW       = $clog2(MIN_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xing,
  input  logic [CW-1:0] per_now,
  input  logic          fast,
  output logic          out_a,
  output logic          out_b
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  pstate_e           state;
  logic [KW-1:0]     cnt;
  logic [PEND_W-1:0] pend, pend_nx;
  logic              side;
  logic              can_start, start;
  logic [CW-1:0]     half;
  logic [KW-1:0]     wid;

  always_comb begin
    can_start = (state == PS_IDLE) || (state == PS_GAP && cnt == KW'(1));
    start     = can_start && (xing || pend != '0);
    half      = per_now >> 1;
    if (!fast)              wid = KW'(WIDTH_NOM);
    else if (half == '0)    wid = KW'(1);
    else                    wid = KW'(half);
    pend_nx = pend;
    if (xing && !start) begin
      if (pend != PEND_MAX) pend_nx = pend + PEND_W'(1);
    end else if (!xing && start) begin
      pend_nx = pend - PEND_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_IDLE;
      cnt   <= '0;
      pend  <= '0;
      side  <= 1'b0;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      pend <= pend_nx;
      if (start) begin
        state <= PS_HIGH;
        cnt   <= wid;
        out_a <= !side;
        out_b <= side;
        side  <= !side;
      end else begin
        case (state)
          PS_HIGH: begin
            if (cnt == KW'(1)) begin
              out_a <= 1'b0;
              out_b <= 1'b0;
              state <= PS_GAP;
              cnt   <= KW'(MIN_GAP);
            end else begin
              cnt <= cnt - KW'(1);
            end
          end
          PS_GAP: begin
            if (cnt == KW'(1)) state <= PS_IDLE;
            else               cnt   <= cnt - KW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // checker state
  logic [GW-1:0] low_run;
  logic          chk_last_b;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run    <= GW'(MIN_GAP);
      chk_last_b <= 1'b1;
    end else begin
      if (out_a || out_b)              low_run <= '0;
      else if (low_run < GW'(MIN_GAP)) low_run <= low_run + GW'(1);
      if (out_a && !out_b) chk_last_b <= 1'b0;
      if (out_b && !out_a) chk_last_b <= 1'b1;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b)); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b)); // R4
  AST_ALT_A: assert property (@(posedge clk) disable iff (rst)
    $rose(out_a) |-> chk_last_b); // R4
  AST_ALT_B: assert property (@(posedge clk) disable iff (rst)
    $rose(out_b) |-> !chk_last_b); // R4
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(out_a || out_b) |-> (low_run >= GW'(MIN_GAP))); // R7
endmodule

// File: rtl/dual_phase_pulser.sv
module dual_phase_pulser #(
  parameter int PWR_W      = 16,
  parameter int ACC_W      = 32,
  parameter int BASE_THR   = 1048576,
  parameter int NOLOAD_MIN = 2,
  parameter int WIDTH_NOM  = 2750000,
  parameter int MIN_GAP    = 4,
  parameter int PEND_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [PWR_W-1:0] smp_pwr,
  input  logic [1:0]              rate_sel,
  input  logic                    nold_en,
  output logic                    out_a,
  output logic                    out_b
);
  localparam int CAP = 2 * WIDTH_NOM;
  localparam int CW  = $clog2(CAP + 1);

  logic          xing;
  logic [CW-1:0] per_now;
  logic          fast;

  dpp_accum #(
    .PWR_W(PWR_W), .ACC_W(ACC_W), .BASE_THR(BASE_THR), .NOLOAD_MIN(NOLOAD_MIN)
  ) u_accum (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
    .rate_sel(rate_sel), .nold_en(nold_en), .xing(xing)
  );

  dpp_period #(.CAP(CAP)) u_period (
    .clk(clk), .rst(rst), .xing(xing), .per_now(per_now), .fast(fast)
  );

  dpp_driver #(
    .WIDTH_NOM(WIDTH_NOM), .MIN_GAP(MIN_GAP), .PEND_W(PEND_W), .CAP(CAP)
  ) u_driver (
    .clk(clk), .rst(rst), .xing(xing), .per_now(per_now), .fast(fast),
    .out_a(out_a), .out_b(out_b)
  );
endmodule

// File: tb/tb_dual_phase_pulser.sv
`timescale 1ns/1ps
module tb_dual_phase_pulser;
  localparam int PW   = 12;
  localparam int THR  = 64;
  localparam int WN   = 20;
  localparam int GAP  = 4;
  localparam int NLM  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [PW-1:0] smp_pwr = '0;
  logic [1:0] rate_sel = 2'd0;
  logic nold_en = 1'b0;
  logic out_a, out_b;

  always #2.5 clk = ~clk;

  dual_phase_pulser #(
    .PWR_W(PW), .ACC_W(16), .BASE_THR(THR), .NOLOAD_MIN(NLM),
    .WIDTH_NOM(WN), .MIN_GAP(GAP), .PEND_W(3)
  ) dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
    .rate_sel(rate_sel), .nold_en(nold_en), .out_a(out_a), .out_b(out_b)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // output monitor
  int cnt_a, cnt_b, run_a, run_b, w_last_a, w_last_b, w_min, gap_min, low_run, alt_err, ovl_err;
  bit prev_a, prev_b, last_was_a, any_seen, fell_seen;

  task automatic clr_mon();
    cnt_a = 0; cnt_b = 0; run_a = 0; run_b = 0; w_last_a = 0; w_last_b = 0;
    w_min = 1000; gap_min = 1000; low_run = 0; alt_err = 0; ovl_err = 0;
    prev_a = 0; prev_b = 0; last_was_a = 0; any_seen = 0; fell_seen = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_a && out_b) ovl_err++;
      if ((out_a && !prev_a) || (out_b && !prev_b)) begin
        if (fell_seen && low_run < gap_min) gap_min = low_run;
        if (out_a && !prev_a) begin
          if (any_seen ? last_was_a : 1'b0) alt_err++;
          cnt_a++; last_was_a = 1'b1;
        end else begin
          if (any_seen ? !last_was_a : 1'b1) alt_err++;
          cnt_b++; last_was_a = 1'b0;
        end
        any_seen = 1'b1;
      end
      if (!out_a && prev_a) begin w_last_a = run_a; if (run_a < w_min) w_min = run_a; fell_seen = 1; end
      if (!out_b && prev_b) begin w_last_b = run_b; if (run_b < w_min) w_min = run_b; fell_seen = 1; end
      run_a = out_a ? run_a + 1 : 0;
      run_b = out_b ? run_b + 1 : 0;
      low_run = (out_a || out_b) ? 0 : low_run + 1;
      prev_a = out_a; prev_b = out_b;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; smp_vld = 1'b0; smp_pwr = '0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    clr_mon();
  endtask

  task automatic send(input int s, input int every);
    smp_vld = 1'b1; smp_pwr = PW'(s);
    @(posedge clk); #1;
    smp_vld = 1'b0;
    repeat (every - 1) @(posedge clk);
    #1;
  endtask

  task automatic run_const(input int s, input int every, input int n);
    for (int i = 0; i < n; i++) send(s, every);
  endtask

  task automatic drain();
    repeat (400) @(posedge clk);
    #1;
  endtask

  initial begin
    clr_mon();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_a && !out_b, "R1", "outputs low in reset", {out_a, out_b}, 0);
    #1 rst = 1'b0; clr_mon();

    // R2: strobe low means the sample is ignored
    smp_pwr = 12'sd500; smp_vld = 1'b0;
    repeat (100) @(posedge clk);
    #1;
    check(cnt_a + cnt_b == 0, "R2", "pulses with strobe low", cnt_a + cnt_b, 0);

    // R1: reset clears the accumulator (62 before reset, 62 after)
    run_const(2, 1, 31);
    do_reset();
    run_const(2, 1, 31);
    drain();
    check(cnt_a + cnt_b == 0, "R1", "residue after reset", cnt_a + cnt_b, 0);
    send(2, 1); drain();
    check(cnt_a == 1 && cnt_b == 0, "R1", "first pulse on out_a", cnt_a * 10 + cnt_b, 10);

    // R2 R3 R4: sweep of rate select and magnitude
    for (int rs = 0; rs < 4; rs++) begin
      for (int k = 0; k < 4; k++) begin
        int s, n;
        s = 2 * k + 1;
        do_reset();
        rate_sel = 2'(rs);
        run_const(s, 8, 60);
        drain();
        n = (60 * s) / (THR >> rs);
        check(cnt_a == (n + 1) / 2, "R3", $sformatf("out_a count rs=%0d s=%0d", rs, s), cnt_a, (n + 1) / 2);
        check(cnt_b == n / 2, "R2", $sformatf("out_b count rs=%0d s=%0d", rs, s), cnt_b, n / 2);
        check(alt_err == 0 && ovl_err == 0, "R4", $sformatf("alternation rs=%0d s=%0d", rs, s), alt_err + ovl_err, 0);
      end
    end
    rate_sel = 2'd0;

    // R5 / R6: width rule around 2*WN
    do_reset(); run_const(1, 1, 192); drain();
    check(w_last_a == WN && w_last_b == WN, "R5", "width at period 64", w_last_a * 100 + w_last_b, WN * 101);
    do_reset(); run_const(8, 5, 40); drain();
    check(w_last_a == WN && w_last_b == WN, "R5", "width at period 40", w_last_a * 100 + w_last_b, WN * 101);
    do_reset(); run_const(2, 1, 160); drain();
    check(w_last_a == 16 && w_last_b == 16, "R6", "width at period 32", w_last_a * 100 + w_last_b, 1616);
    do_reset(); run_const(4, 1, 160); drain();
    check(w_last_a == 8 && w_last_b == 8, "R6", "width at period 16", w_last_a * 100 + w_last_b, 808);
    check(cnt_a + cnt_b == 10, "R8", "queued crossings all issued", cnt_a + cnt_b, 10);

    // R7: saturating burst at the fastest rate
    do_reset(); rate_sel = 2'd3; run_const(7, 1, 64); drain();
    check(gap_min == GAP, "R7", "minimum low gap", gap_min, GAP);
    check(w_min == 1, "R6", "width floor of one cycle", w_min, 1);
    check(alt_err == 0 && ovl_err == 0, "R4", "alternation in burst", alt_err + ovl_err, 0);
    rate_sel = 2'd0;

    // R9: no-load guard
    do_reset(); nold_en = 1'b1;
    run_const(2, 1, 30); run_const(3, 1, 21); drain();
    check(cnt_a + cnt_b == 0, "R9", "no pulse after held-zero then 63", cnt_a + cnt_b, 0);
    send(3, 1); drain();
    check(cnt_a + cnt_b == 1, "R9", "pulse at 66 after guard", cnt_a + cnt_b, 1);
    do_reset(); nold_en = 1'b0;
    run_const(2, 1, 32); drain();
    check(cnt_a + cnt_b == 1, "R9", "guard off accumulates small samples", cnt_a + cnt_b, 1);

    // R10: negative samples
    do_reset();
    run_const(5, 1, 10); run_const(-5, 1, 3); run_const(5, 1, 5); drain();
    check(cnt_a + cnt_b == 0, "R10", "sum 60 after cancellation", cnt_a + cnt_b, 0);
    send(5, 1); drain();
    check(cnt_a + cnt_b == 1, "R10", "sum 65 gives pulse", cnt_a + cnt_b, 1);
    do_reset();
    run_const(-5, 1, 20); drain();
    check(cnt_a + cnt_b == 0, "R10", "negative power pulses", cnt_a + cnt_b, 0);
    run_const(5, 1, 12); drain();
    check(cnt_a + cnt_b == 0, "R10", "floor at zero then 60", cnt_a + cnt_b, 0);
    send(5, 1); drain();
    check(cnt_a + cnt_b == 1, "R10", "floor at zero then 65", cnt_a + cnt_b, 1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule